// File: doc/BRIEF.md
# Intra DC Coefficient Reconstructor

This block turns the DC differences carried by intra-coded blocks back into absolute DC coefficients. Each block delivers one signed difference. The block scales the difference by eight and adds it to a base value. The base is either the running prediction for that colour component or the fixed mid-level value 1024 (128 times 8). Three separate predictors are kept, one each for luminance, blue-difference chroma and red-difference chroma. Every reconstructed value becomes the new predictor for its component.

A macroblock is presented as six block strobes, with the block index giving the position inside the macroblock. When an intra macroblock does not directly follow the previously closed intra macroblock in address order, the first block of each component restarts from the mid-level base. The same happens after reset and after a slice-start pulse. Non-intra blocks pass by without touching any state. The result appears on a registered output one clock after the block strobe.

Top module: `intra_dc_recon`

## Requirements
- R1: Block index 0..3 selects luminance, 4 selects blue chroma and 5 selects red chroma. A strobe with index 6 or 7 gives no output and changes no predictor or address history.
- R2: For an accepted block (blk_valid=1, blk_intra=1, index 0..5), out_valid is 1 in the following cycle and out_dc equals base + 8*dc_diff, with dc_diff sign-extended and the sum taken modulo 2^DC_W. In every other cycle out_valid is 0.
- R3: For index 0, the base is 1024 when no intra macroblock address is on record, or when (mb_addr - last intra address) modulo 2^ADDR_W is greater than 1. Otherwise the base is the luminance predictor. An equal address counts as a difference of 0.
- R4: Indices 1, 2 and 3 always use the luminance predictor as base.
- R5: Index 4 and index 5 apply the rule of R3, each with its own chroma predictor. These predictors carry across macroblocks independently of luminance and of each other.
- R6: After an accepted block, the predictor of that block's component holds the reconstructed value. The other two predictors are unchanged.
- R7: A strobe with blk_intra=0 gives no output and changes no predictor or address history.
- R8: An accepted index-5 block records mb_addr as the last intra macroblock address and marks the history valid.
- R9: A slice_start pulse makes the next macroblock start every component from 1024. A block strobed in the same cycle is still processed with the prior state. If that block is an index-5 block, the pulse wins over the history it would have validated.
- R10: While rst is high and in the cycle after it, out_valid is 0. After reset, no address history exists.

Requirements R1, R7 and R10 state that something is ignored or held. The bench checks these through out_valid, and through the out_dc value of the next accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_start | input | 1 | One-cycle pulse that invalidates the address history |
| blk_valid | input | 1 | Block strobe |
| blk_intra | input | 1 | Block belongs to an intra macroblock |
| blk_idx | input | 3 | Block position inside the macroblock (0..3 luma, 4 Cb, 5 Cr) |
| mb_addr | input | ADDR_W | Macroblock address of the block |
| dc_diff | input | DIFF_W | Signed transmitted DC difference |
| out_valid | output | 1 | Reconstructed value present |
| out_dc | output | DC_W | Signed reconstructed DC value |

## Verification
The interaction that needs care is a slice-start pulse arriving in the same cycle as the closing red-chroma block of an intra macroblock. In that cycle the block wants to validate the address history and the pulse wants to clear it. The stimulus table drives both together on macroblock 11, then presents macroblock 12 at the adjacent address. A correct design must rebuild its luminance DC from 1024 rather than from the stored predictor, and must still produce the red-chroma result of the coinciding block from the state before the pulse.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    COMP_Y    = 2'd0,
    COMP_CB   = 2'd1,
    COMP_CR   = 2'd2,
    COMP_NONE = 2'd3
  } comp_e;

  localparam int unsigned NUM_COMP    = 3;
  localparam int unsigned LUMA_BLOCKS = 4;
  localparam int          MID_DC      = 128 * 8;

  // R1: block position to colour component
  function automatic comp_e comp_of(input logic [2:0] idx);
    if (32'(idx) < LUMA_BLOCKS)              return COMP_Y;
    else if (32'(idx) == LUMA_BLOCKS)        return COMP_CB;
    else if (32'(idx) == LUMA_BLOCKS + 1)    return COMP_CR;
    else                                     return COMP_NONE;
  endfunction

  // first block of its component inside a macroblock
  function automatic logic opens_comp(input logic [2:0] idx);
    return (idx == 3'd0) || (32'(idx) == LUMA_BLOCKS) || (32'(idx) == LUMA_BLOCKS + 1);
  endfunction

endpackage

// File: rtl/dcp_addr_hist.sv
module dcp_addr_hist #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slice_start,
  input  logic              mb_close,
  input  logic [ADDR_W-1:0] mb_addr,
  output logic              fresh
);
  logic              hist_ok;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_ok   <= 1'b0;
      last_addr <= '0;
    end else begin
      if (mb_close) begin
        last_addr <= mb_addr;
        hist_ok   <= 1'b1;
      end
      if (slice_start) hist_ok <= 1'b0;
    end
  end

  always_comb begin
    gap   = mb_addr - last_addr;
    fresh = !hist_ok || (gap > ADDR_W'(1));
  end
endmodule

// File: rtl/dcp_pred_bank.sv
module dcp_pred_bank #(
  parameter int DC_W      = 14,
  parameter int NUM       = 3,
  parameter int RESET_VAL = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic signed [DC_W-1:0] wr_data,
  input  logic [1:0]             rd_sel,
  output logic signed [DC_W-1:0] rd_data
);
  logic signed [DC_W-1:0] pred_q [NUM];

  for (genvar c = 0; c < NUM; c++) begin : g_pred
    always_ff @(posedge clk) begin
      if (rst)                              pred_q[c] <= DC_W'(RESET_VAL);
      else if (wr_en && wr_sel == 2'(c))    pred_q[c] <= wr_data;
    end
  end

  always_comb begin
    rd_data = pred_q[0];
    for (int c = 1; c < NUM; c++)
      if (rd_sel == 2'(c)) rd_data = pred_q[c];
  end
endmodule

// File: rtl/intra_dc_recon.sv
module intra_dc_recon
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DIFF_W = 9,
  parameter int DC_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slice_start,
  input  logic                     blk_valid,
  input  logic                     blk_intra,
  input  logic [2:0]               blk_idx,
  input  logic [ADDR_W-1:0]        mb_addr,
  input  logic signed [DIFF_W-1:0] dc_diff,
  output logic                     out_valid,
  output logic signed [DC_W-1:0]   out_dc
);
  localparam int                     SCALE_SH = 3;
  localparam logic signed [DC_W-1:0] BASE_VAL = DC_W'(MID_DC);

  function automatic logic signed [DC_W-1:0] dc_add(
    input logic signed [DC_W-1:0]   base,
    input logic signed [DIFF_W-1:0] d
  );
    logic signed [DC_W-1:0] ext;
    ext = DC_W'(d);
    return base + (ext <<< SCALE_SH);
  endfunction

  comp_e                  comp_sel;
  logic                   blk_fire;
  logic                   first_blk;
  logic                   fresh;
  logic                   use_base;
  logic                   mb_close;
  logic signed [DC_W-1:0] pred_rd;
  logic signed [DC_W-1:0] recon;

  always_comb begin
    comp_sel  = comp_of(blk_idx);
    blk_fire  = blk_valid && blk_intra && (comp_sel != COMP_NONE);
    first_blk = opens_comp(blk_idx);
    use_base  = first_blk && fresh;
    mb_close  = blk_fire && (comp_sel == COMP_CR);
    recon     = dc_add(use_base ? BASE_VAL : pred_rd, dc_diff);
  end

  dcp_addr_hist #(.ADDR_W(ADDR_W)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .slice_start (slice_start),
    .mb_close    (mb_close),
    .mb_addr     (mb_addr),
    .fresh       (fresh)
  );

  dcp_pred_bank #(.DC_W(DC_W), .NUM(NUM_COMP), .RESET_VAL(MID_DC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (blk_fire),
    .wr_sel  (comp_sel),
    .wr_data (recon),
    .rd_sel  (comp_sel),
    .rd_data (pred_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dc    <= '0;
    end else begin
      out_valid <= blk_fire;
      if (blk_fire) out_dc <= recon;
    end
  end
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker (
  input logic       clk,
  input logic       rst,
  input logic       slice_start,
  input logic       blk_valid,
  input logic       blk_intra,
  input logic [2:0] blk_idx,
  input logic       out_valid,
  input logic       blk_fire,
  input logic       use_base,
  input logic       mb_close
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)              pending <= 1'b1;
    else if (slice_start) pending <= 1'b1;
    else if (mb_close)    pending <= 1'b0;
  end

  // R1
  idx_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_idx > 3'd5) |=> !out_valid);

  // R7
  nonintra_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_intra) |=> !out_valid);

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    blk_fire |=> out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_fire |=> !out_valid);

  // R4
  luma_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_fire && blk_idx >= 3'd1 && blk_idx <= 3'd3) |-> !use_base);

  // R3
  base_on_first_chk: assert property (@(posedge clk) disable iff (rst)
    use_base |-> (blk_idx == 3'd0 || blk_idx == 3'd4 || blk_idx == 3'd5));

  // R9
  restart_after_slice_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_fire && blk_idx == 3'd0 && pending) |-> use_base);
endmodule

bind intra_dc_recon dcp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .slice_start (slice_start),
  .blk_valid   (blk_valid),
  .blk_intra   (blk_intra),
  .blk_idx     (blk_idx),
  .out_valid   (out_valid),
  .blk_fire    (blk_fire),
  .use_base    (use_base),
  .mb_close    (mb_close)
);

// File: tb/intra_dc_recon_test.sv
module intra_dc_recon_test;
  localparam int ADDR_W = 11;
  localparam int DIFF_W = 9;
  localparam int DC_W   = 14;

  typedef struct packed {
    logic [3:0]               req;
    logic                     sl;
    logic                     vld;
    logic                     intra;
    logic [2:0]               idx;
    logic [ADDR_W-1:0]        addr;
    logic signed [DIFF_W-1:0] diff;
    logic                     ev;
    logic signed [DC_W-1:0]   edc;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 1'b0,1'b1,1'b1,3'd0,11'd5, 9'sd3,  1'b1,14'sd1048}, // R3 no history -> 1024+24
    '{4'd4, 1'b0,1'b1,1'b1,3'd1,11'd5,-9'sd2,  1'b1,14'sd1032}, // R4
    '{4'd4, 1'b0,1'b1,1'b1,3'd2,11'd5, 9'sd0,  1'b1,14'sd1032}, // R4
    '{4'd4, 1'b0,1'b1,1'b1,3'd3,11'd5, 9'sd5,  1'b1,14'sd1072}, // R4
    '{4'd5, 1'b0,1'b1,1'b1,3'd4,11'd5, 9'sd1,  1'b1,14'sd1032}, // R5 Cb base
    '{4'd5, 1'b0,1'b1,1'b1,3'd5,11'd5,-9'sd4,  1'b1,14'sd992 }, // R5 Cr base
    '{4'd3, 1'b0,1'b1,1'b1,3'd0,11'd6, 9'sd2,  1'b1,14'sd1088}, // R3 adjacent -> predictor
    '{4'd4, 1'b0,1'b1,1'b1,3'd1,11'd6, 9'sd0,  1'b1,14'sd1088}, // R4
    '{4'd4, 1'b0,1'b1,1'b1,3'd2,11'd6, 9'sd1,  1'b1,14'sd1096}, // R4
    '{4'd6, 1'b0,1'b1,1'b1,3'd3,11'd6,-9'sd1,  1'b1,14'sd1088}, // R6
    '{4'd5, 1'b0,1'b1,1'b1,3'd4,11'd6, 9'sd2,  1'b1,14'sd1048}, // R5 Cb carried
    '{4'd6, 1'b0,1'b1,1'b1,3'd5,11'd6, 9'sd1,  1'b1,14'sd1000}, // R6 Cr carried
    '{4'd7, 1'b0,1'b1,1'b0,3'd0,11'd7, 9'sd9,  1'b0,14'sd0   }, // R7 non-intra
    '{4'd7, 1'b0,1'b1,1'b0,3'd4,11'd7, 9'sd9,  1'b0,14'sd0   }, // R7 non-intra
    '{4'd8, 1'b0,1'b1,1'b1,3'd0,11'd8, 9'sd1,  1'b1,14'sd1032}, // R8 gap of 2 -> base
    '{4'd4, 1'b0,1'b1,1'b1,3'd1,11'd8, 9'sd1,  1'b1,14'sd1040}, // R4
    '{4'd4, 1'b0,1'b1,1'b1,3'd2,11'd8, 9'sd0,  1'b1,14'sd1040}, // R4
    '{4'd4, 1'b0,1'b1,1'b1,3'd3,11'd8, 9'sd0,  1'b1,14'sd1040}, // R4
    '{4'd5, 1'b0,1'b1,1'b1,3'd4,11'd8, 9'sd0,  1'b1,14'sd1024}, // R5 gap -> Cb base
    '{4'd5, 1'b0,1'b1,1'b1,3'd5,11'd8, 9'sd3,  1'b1,14'sd1048}, // R5 gap -> Cr base
    '{4'd1, 1'b0,1'b1,1'b1,3'd6,11'd8, 9'sd50, 1'b0,14'sd0   }, // R1 unused index
    '{4'd1, 1'b0,1'b1,1'b1,3'd0,11'd9,-9'sd1,  1'b1,14'sd1032}, // R1 luma untouched
    '{4'd2, 1'b0,1'b0,1'b1,3'd0,11'd9, 9'sd0,  1'b0,14'sd0   }, // R2 idle
    '{4'd5, 1'b0,1'b1,1'b1,3'd4,11'd9, 9'sd1,  1'b1,14'sd1032}, // R5
    '{4'd6, 1'b0,1'b1,1'b1,3'd5,11'd9, 9'sd0,  1'b1,14'sd1048}, // R6
    '{4'd9, 1'b1,1'b0,1'b0,3'd0,11'd9, 9'sd0,  1'b0,14'sd0   }, // R9 slice pulse
    '{4'd9, 1'b0,1'b1,1'b1,3'd0,11'd10,9'sd0,  1'b1,14'sd1024}, // R9 base despite adjacency
    '{4'd9, 1'b0,1'b1,1'b1,3'd4,11'd10,9'sd2,  1'b1,14'sd1040}, // R9
    '{4'd9, 1'b0,1'b1,1'b1,3'd5,11'd10,9'sd2,  1'b1,14'sd1040}, // R9
    '{4'd3, 1'b0,1'b1,1'b1,3'd0,11'd11,9'sd1,  1'b1,14'sd1032}, // R3 history restored
    '{4'd9, 1'b1,1'b1,1'b1,3'd5,11'd11,9'sd1,  1'b1,14'sd1048}, // R9 pulse with Cr close
    '{4'd9, 1'b0,1'b1,1'b1,3'd0,11'd12,9'sd2,  1'b1,14'sd1040}, // R9 pulse won -> base
    '{4'd5, 1'b0,1'b1,1'b1,3'd4,11'd12,9'sd0,  1'b1,14'sd1024}, // R5
    '{4'd8, 1'b0,1'b1,1'b1,3'd5,11'd12,9'sd0,  1'b1,14'sd1024}, // R8 records 12
    '{4'd3, 1'b0,1'b1,1'b1,3'd0,11'd12,9'sd1,  1'b1,14'sd1048}  // R3 equal address
  };

  logic                     clk = 1'b0;
  logic                     rst;
  logic                     slice_start;
  logic                     blk_valid;
  logic                     blk_intra;
  logic [2:0]               blk_idx;
  logic [ADDR_W-1:0]        mb_addr;
  logic signed [DIFF_W-1:0] dc_diff;
  logic                     out_valid;
  logic signed [DC_W-1:0]   out_dc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  intra_dc_recon #(.ADDR_W(ADDR_W), .DIFF_W(DIFF_W), .DC_W(DC_W)) uut (
    .clk(clk), .rst(rst), .slice_start(slice_start), .blk_valid(blk_valid),
    .blk_intra(blk_intra), .blk_idx(blk_idx), .mb_addr(mb_addr), .dc_diff(dc_diff),
    .out_valid(out_valid), .out_dc(out_dc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    slice_start = v.sl;
    blk_valid   = v.vld;
    blk_intra   = v.intra;
    blk_idx     = v.idx;
    mb_addr     = v.addr;
    dc_diff     = v.diff;
  endtask

  task automatic idle();
    slice_start = 1'b0; blk_valid = 1'b0; blk_intra = 1'b0;
    blk_idx = 3'd0; mb_addr = '0; dc_diff = '0;
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    chk("R10 out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", int'(out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d out_valid", TBL[i].req, i), int'(out_valid), int'(TBL[i].ev));
      if (TBL[i].ev)
        chk($sformatf("R%0d vec %0d out_dc", TBL[i].req, i), int'(out_dc), int'(TBL[i].edc));
    end

    // R10: mid-run reset clears history; adjacent address 13 still starts from 1024
    idle();
    rst = 1'b1;
    @(negedge clk);
    chk("R10 out_valid in mid reset", int'(out_valid), 0);
    rst = 1'b0;
    blk_valid = 1'b1; blk_intra = 1'b1; blk_idx = 3'd0; mb_addr = 11'd13; dc_diff = 9'sd0;
    @(negedge clk);
    chk("R10 base after reset", int'(out_dc), 1024);

    // R2: negative difference down to a small value
    blk_idx = 3'd1; dc_diff = -9'sd100;
    @(negedge clk);
    chk("R2 negative diff", int'(out_dc), 224);
    idle();
    @(negedge clk);
    chk("R2 single-cycle valid", int'(out_valid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule